// File: doc/BRIEF.md
# Audio Clock Supervisor

This block watches the three serial audio clocks (system clock, bit clock, word clock). A separate free-running reference clock does the watching. It decides whether the downstream converter may run, and from which clock source. Each raw clock passes through a two-flop synchronizer. The block then counts edges between word-clock rising edges, which gives one measurement per sample frame: bit-clock edges and system-clock edges.

From these frame measurements the block takes five decisions:
- It holds the core in reset until the supply has been good for a set time.
- It falls back to the system clock derived from the bit clock when no external system clock arrives.
- It drops lock, and forces the output to bipolar zero, when the framing or the system-clock rate goes wrong.
- It regains lock once clean frames return.
- It raises a standby request on errors or halts, and a power-down request after a long silence on both serial clocks.

Recovery from standby and power-down is automatic once valid frames return. The reference clock must run at least four times faster than any monitored clock.

Top module: `aclk_supervisor`

## Requirements
- R1: `core_rst` stays high until the synchronized `supply_ok` has been high for RST_CYC consecutive reference cycles. It goes high again within three cycles of `supply_ok` falling.
- R2: After ABSENT_FRAMES (16) consecutive frames that have a valid bit-clock ratio and no system-clock edge, `use_pll_sck` goes high at the end of the 16th such frame.
- R3: A frame that contains at least one external system-clock edge clears `use_pll_sck` at its end.
- R4: If the system-clock edge count of a frame differs by more than DRIFT_TOL (5) from the previous frame, `force_bpz` is high right after that frame ends. This applies only when both frames had the same valid bit-clock count and an external system clock. `standby_req` goes high at the same point.
- R5: A frame-to-frame system-clock count change of at most 5 leaves `force_bpz` low.
- R6: A frame counts as valid when it has exactly 32, 48 or 64 bit-clock rising edges between word-clock rising edges. Up to LOSS_FRAMES (4) consecutive invalid frames keep lock. The 5th consecutive invalid frame drops lock, which raises `force_bpz` and `standby_req`.
- R7: After a loss of lock, `force_bpz` falls at the end of the 2nd consecutive good frame.
- R8: `standby_req` is high while the bit clock has shown no edge for IDLE_CYC reference cycles, and while a lock fault is pending.
- R9: `powerdown_req` rises after the bit clock and word clock have both been low for PD_CYC reference cycles. It falls when lock is regained.
- R10: `force_bpz` is high during and right after internal reset, and until the first lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Supply-good indication, asynchronous |
| sck_in | input | 1 | Raw system clock |
| bck_in | input | 1 | Raw bit clock |
| lrck_in | input | 1 | Raw word clock (rising edge starts a frame) |
| core_rst | output | 1 | Internal reset for the converter core |
| use_pll_sck | output | 1 | Select the system clock derived from the bit clock |
| force_bpz | output | 1 | Force output to bipolar zero |
| standby_req | output | 1 | Standby request |
| powerdown_req | output | 1 | Full power-down request |

## Verification
The embedded properties assume the following about the inputs:
- Bit-clock and word-clock rising edges never fall in the same reference cycle.
- Every monitored clock holds each level for at least two reference cycles, so no edge is lost in synchronization.

The stimulus generator meets both conditions. It derives all three clocks from the reference clock: the bit clock toggles every four cycles, the word clock changes only on bit-clock falling edges, and the system clock toggles every two cycles. Ratio and system-clock enable changes take effect only at a word-clock rising edge, so every measured frame is whole. A system-clock stall is always placed well inside a single frame.

// File: rtl/aclk_sup_pkg.sv
package aclk_sup_pkg;

    // Width of the per-frame bit-clock edge counter (holds up to 64 and the overflow step).
    localparam int unsigned BITS_W    = 7;
    // Width of the per-frame system-clock edge counter (saturating).
    localparam int unsigned SCK_CNT_W = 12;
    // Largest legal bit-clock count per frame.
    localparam logic [BITS_W-1:0] MAX_BITS = BITS_W'(64);

    // Synchronizer channel positions.
    localparam int unsigned CH_SCK  = 0;
    localparam int unsigned CH_BCK  = 1;
    localparam int unsigned CH_LRCK = 2;
    localparam int unsigned CH_PWR  = 3;
    localparam int unsigned N_CH    = 4;

    typedef enum logic {
        LK_HUNT = 1'b0,
        LK_HELD = 1'b1
    } lock_e;

    typedef struct packed {
        logic [BITS_W-1:0]    bits;
        logic [SCK_CNT_W-1:0] sclk;
    } frame_cnt_t;

    function automatic logic ratio_ok(input logic [BITS_W-1:0] b);
        case (b)
            BITS_W'(32), BITS_W'(48), BITS_W'(64): ratio_ok = 1'b1;
            default:                               ratio_ok = 1'b0;
        endcase
    endfunction

    function automatic logic [SCK_CNT_W-1:0] abs_gap(input logic [SCK_CNT_W-1:0] a,
                                                     input logic [SCK_CNT_W-1:0] b);
        abs_gap = (a > b) ? (a - b) : (b - a);
    endfunction

endpackage

// File: rtl/aclk_sync.sv
module aclk_sync #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw,
    output logic [N-1:0] lvl
);

    for (genvar i = 0; i < N; i++) begin : g_ch
        logic meta_q;
        logic stab_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= raw[i];
                stab_q <= meta_q;
            end
        end
        assign lvl[i] = stab_q;
    end

endmodule

// File: rtl/aclk_frame_monitor.sv
module aclk_frame_monitor
    import aclk_sup_pkg::*;
#(
    parameter int unsigned ABSENT_FRAMES = 16,
    parameter int unsigned LOSS_FRAMES   = 4,
    parameter int unsigned RELOCK_FRAMES = 2,
    parameter int unsigned DRIFT_TOL     = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic sck_s,
    input  logic bck_s,
    input  logic lrck_s,
    input  logic halted,
    output logic locked,
    output logic use_pll,
    output logic fault
);

    localparam int unsigned AW = $clog2(ABSENT_FRAMES + 1);
    localparam int unsigned LW = $clog2(LOSS_FRAMES + 1);
    localparam int unsigned GW = $clog2(RELOCK_FRAMES + 1);
    localparam logic [SCK_CNT_W-1:0] TOL_V = SCK_CNT_W'(DRIFT_TOL);

    logic       sck_d, bck_d, lrck_d;
    frame_cnt_t cur, prev;
    logic       prev_ok, primed;
    logic [AW-1:0] absent_run;
    logic [LW-1:0] bad_run;
    logic [GW-1:0] good_run;
    lock_e      lock_st;

    logic sck_rise, bck_rise, lrck_rise;
    logic ovf, frame_end, r_ok, s_seen, cmp, drift, good;

    always_comb begin
        sck_rise  = sck_s  & ~sck_d;
        bck_rise  = bck_s  & ~bck_d;
        lrck_rise = lrck_s & ~lrck_d;
        ovf       = bck_rise && (cur.bits == MAX_BITS) && !lrck_rise;
        frame_end = (lrck_rise && primed) || ovf;
        r_ok      = !ovf && ratio_ok(cur.bits);
        s_seen    = (cur.sclk != '0);
        cmp       = r_ok && prev_ok && (cur.bits == prev.bits) &&
                    (prev.sclk != '0) && s_seen && !use_pll;
        drift     = cmp && (abs_gap(cur.sclk, prev.sclk) > TOL_V);
        good      = r_ok && (use_pll || s_seen) && !drift;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d      <= 1'b0;
            bck_d      <= 1'b0;
            lrck_d     <= 1'b0;
            cur        <= '0;
            prev       <= '0;
            prev_ok    <= 1'b0;
            primed     <= 1'b0;
            absent_run <= '0;
            bad_run    <= '0;
            good_run   <= '0;
            lock_st    <= LK_HUNT;
            use_pll    <= 1'b0;
            fault      <= 1'b0;
        end else begin
            sck_d  <= sck_s;
            bck_d  <= bck_s;
            lrck_d <= lrck_s;
            if (halted) begin
                cur      <= '0;
                primed   <= 1'b0;
                prev_ok  <= 1'b0;
                bad_run  <= '0;
                good_run <= '0;
                lock_st  <= LK_HUNT;
                fault    <= 1'b1;
            end else begin
                // per-frame edge counting
                if (lrck_rise) begin
                    cur.bits <= '0;
                    cur.sclk <= SCK_CNT_W'(sck_rise);
                    primed   <= 1'b1;
                end else if (ovf) begin
                    cur    <= '0;
                    primed <= 1'b0;
                end else begin
                    cur.bits <= cur.bits + BITS_W'(bck_rise);
                    if (sck_rise && (cur.sclk != '1))
                        cur.sclk <= cur.sclk + 1'b1;
                end

                if (frame_end) begin
                    prev    <= cur;
                    prev_ok <= r_ok;

                    // clock source selection
                    if (s_seen) begin
                        use_pll    <= 1'b0;
                        absent_run <= '0;
                    end else if (r_ok) begin
                        if (absent_run >= AW'(ABSENT_FRAMES - 1))
                            use_pll <= 1'b1;
                        if (absent_run < AW'(ABSENT_FRAMES))
                            absent_run <= absent_run + 1'b1;
                    end else begin
                        absent_run <= '0;
                    end

                    // lock tracking
                    if (!good) begin
                        good_run <= '0;
                        if (drift || (bad_run >= LW'(LOSS_FRAMES))) begin
                            lock_st <= LK_HUNT;
                            fault   <= 1'b1;
                        end
                        if (bad_run < LW'(LOSS_FRAMES))
                            bad_run <= bad_run + 1'b1;
                    end else begin
                        bad_run <= '0;
                        if (good_run >= GW'(RELOCK_FRAMES - 1)) begin
                            lock_st <= LK_HELD;
                            fault   <= 1'b0;
                        end
                        if (good_run < GW'(RELOCK_FRAMES))
                            good_run <= good_run + 1'b1;
                    end
                end
            end
        end
    end

    assign locked = (lock_st == LK_HELD);

    // R4: a drift frame drops lock in the following cycle
    a_r4_drift_drops_lock: assert property (@(posedge clk) disable iff (rst)
        (frame_end && drift && !halted) |=> !locked);

    // R7: lock is only ever gained at a frame boundary
    a_r7_lock_at_frame_end: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(frame_end));

    // R2: the derived-clock select only rises after a frame without system-clock edges
    a_r2_pll_after_silent_frame: assert property (@(posedge clk) disable iff (rst)
        $rose(use_pll) |-> $past(frame_end && (cur.sclk == '0)));

    // R3: a frame with external system-clock edges releases the derived-clock select
    a_r3_ext_sck_clears_pll: assert property (@(posedge clk) disable iff (rst)
        (frame_end && s_seen && !halted) |=> !use_pll);

endmodule

// File: rtl/aclk_power_ctrl.sv
module aclk_power_ctrl #(
    parameter int unsigned RST_CYC  = 98304,
    parameter int unsigned IDLE_CYC = 64,
    parameter int unsigned PD_CYC   = 24576000
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_s,
    input  logic bck_s,
    input  logic lrck_s,
    input  logic locked,
    output logic core_rst,
    output logic halted,
    output logic powerdown_req
);

    localparam int unsigned RW = $clog2(RST_CYC + 1);
    localparam int unsigned IW = $clog2(IDLE_CYC + 1);
    localparam int unsigned PW = $clog2(PD_CYC + 1);
    localparam logic [RW-1:0] RST_V  = RW'(RST_CYC);
    localparam logic [IW-1:0] IDLE_V = IW'(IDLE_CYC);
    localparam logic [PW-1:0] PD_V   = PW'(PD_CYC);

    logic [RW-1:0] rcnt;
    logic [IW-1:0] idle_cnt;
    logic [PW-1:0] pd_cnt;
    logic          bck_d;
    logic          quiet;

    assign quiet = !bck_s && !lrck_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            rcnt          <= '0;
            idle_cnt      <= IDLE_V;
            pd_cnt        <= '0;
            bck_d         <= 1'b0;
            powerdown_req <= 1'b0;
        end else begin
            bck_d <= bck_s;

            if (!supply_s)
                rcnt <= '0;
            else if (rcnt != RST_V)
                rcnt <= rcnt + 1'b1;

            if (bck_s != bck_d)
                idle_cnt <= '0;
            else if (idle_cnt != IDLE_V)
                idle_cnt <= idle_cnt + 1'b1;

            if (!quiet)
                pd_cnt <= '0;
            else if (pd_cnt != PD_V)
                pd_cnt <= pd_cnt + 1'b1;

            if (pd_cnt == PD_V)
                powerdown_req <= 1'b1;
            else if (locked)
                powerdown_req <= 1'b0;
        end
    end

    assign core_rst = (rcnt != RST_V);
    assign halted   = (idle_cnt == IDLE_V);

    // R1: a low supply-good holds the core in reset on the next cycle
    a_r1_supply_drop_resets: assert property (@(posedge clk) disable iff (rst)
        !supply_s |=> core_rst);

    // R9: power-down is only requested after both serial clocks sat low
    a_r9_pd_needs_quiet: assert property (@(posedge clk) disable iff (rst)
        $rose(powerdown_req) |-> $past(quiet));

    // R8: halt is declared only when the bit clock did not move
    a_r8_halt_without_edge: assert property (@(posedge clk) disable iff (rst)
        $rose(halted) |-> $past(bck_s == bck_d));

endmodule

// File: rtl/aclk_supervisor.sv
module aclk_supervisor
    import aclk_sup_pkg::*;
#(
    parameter int unsigned RST_CYC       = 98304,
    parameter int unsigned IDLE_CYC      = 64,
    parameter int unsigned PD_CYC        = 24576000,
    parameter int unsigned ABSENT_FRAMES = 16,
    parameter int unsigned LOSS_FRAMES   = 4,
    parameter int unsigned RELOCK_FRAMES = 2,
    parameter int unsigned DRIFT_TOL     = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok,
    input  logic sck_in,
    input  logic bck_in,
    input  logic lrck_in,
    output logic core_rst,
    output logic use_pll_sck,
    output logic force_bpz,
    output logic standby_req,
    output logic powerdown_req
);

    logic [N_CH-1:0] raw, lvl;
    logic            mon_rst, locked, halted, fault;

    always_comb begin
        raw          = '0;
        raw[CH_SCK]  = sck_in;
        raw[CH_BCK]  = bck_in;
        raw[CH_LRCK] = lrck_in;
        raw[CH_PWR]  = supply_ok;
    end

    aclk_sync #(.N(N_CH)) u_sync (
        .clk (clk),
        .rst (rst),
        .raw (raw),
        .lvl (lvl)
    );

    aclk_power_ctrl #(
        .RST_CYC  (RST_CYC),
        .IDLE_CYC (IDLE_CYC),
        .PD_CYC   (PD_CYC)
    ) u_pwr (
        .clk           (clk),
        .rst           (rst),
        .supply_s      (lvl[CH_PWR]),
        .bck_s         (lvl[CH_BCK]),
        .lrck_s        (lvl[CH_LRCK]),
        .locked        (locked),
        .core_rst      (core_rst),
        .halted        (halted),
        .powerdown_req (powerdown_req)
    );

    assign mon_rst = rst | core_rst;

    aclk_frame_monitor #(
        .ABSENT_FRAMES (ABSENT_FRAMES),
        .LOSS_FRAMES   (LOSS_FRAMES),
        .RELOCK_FRAMES (RELOCK_FRAMES),
        .DRIFT_TOL     (DRIFT_TOL)
    ) u_mon (
        .clk     (clk),
        .rst     (mon_rst),
        .sck_s   (lvl[CH_SCK]),
        .bck_s   (lvl[CH_BCK]),
        .lrck_s  (lvl[CH_LRCK]),
        .halted  (halted),
        .locked  (locked),
        .use_pll (use_pll_sck),
        .fault   (fault)
    );

    assign force_bpz   = ~locked;
    assign standby_req = halted | fault | powerdown_req;

    // R10: internal reset always leaves the output forced to bipolar zero
    a_r10_bpz_after_core_rst: assert property (@(posedge clk) disable iff (rst)
        core_rst |=> force_bpz);

endmodule

// File: tb/aclk_supervisor_test.sv
module aclk_supervisor_test;

    localparam int CLK_PERIOD = 10;
    localparam int RST_CYC    = 100;
    localparam int IDLE_CYC   = 64;
    localparam int PD_CYC     = 2000;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst, supply_ok;
    logic sck_raw, bck_raw, lrck_raw;
    logic core_rst, use_pll_sck, force_bpz, standby_req, powerdown_req;

    always #(CLK_PERIOD/2) clk = ~clk;

    aclk_supervisor #(
        .RST_CYC  (RST_CYC),
        .IDLE_CYC (IDLE_CYC),
        .PD_CYC   (PD_CYC)
    ) uut (
        .clk           (clk),
        .rst           (rst),
        .supply_ok     (supply_ok),
        .sck_in        (sck_raw),
        .bck_in        (bck_raw),
        .lrck_in       (lrck_raw),
        .core_rst      (core_rst),
        .use_pll_sck   (use_pll_sck),
        .force_bpz     (force_bpz),
        .standby_req   (standby_req),
        .powerdown_req (powerdown_req)
    );

    // ---------------- clock generator ----------------
    logic run = 1'b0;
    logic was_run = 1'b0;
    int   ratio_next = 32;
    bit   sck_next = 1'b0;
    int   stall_req = 0;
    int   stall_amt = 0;
    int   cur_ratio, bsub, falls, ssub, stall_left, stall_seen;
    bit   sck_on;

    initial begin
        sck_raw = 1'b0; bck_raw = 1'b0; lrck_raw = 1'b0;
        stall_seen = 0; stall_left = 0;
    end

    always @(negedge clk) begin
        if (!run) begin
            bck_raw = 1'b0; lrck_raw = 1'b0; sck_raw = 1'b0;
            was_run = 1'b0;
        end else begin
            if (!was_run) begin
                was_run = 1'b1; bsub = 0; falls = 0; ssub = 0;
                cur_ratio = ratio_next; sck_on = sck_next;
            end
            if (stall_req != stall_seen) begin
                stall_seen = stall_req;
                stall_left = stall_amt;
            end
            bsub = bsub + 1;
            if (bsub == 4) begin
                bsub = 0;
                if (bck_raw) begin
                    bck_raw = 1'b0;
                    falls = falls + 1;
                    if (falls == cur_ratio/2) begin
                        falls = 0;
                        lrck_raw = ~lrck_raw;
                        if (lrck_raw) begin
                            cur_ratio = ratio_next;
                            sck_on = sck_next;
                        end
                    end
                end else begin
                    bck_raw = 1'b1;
                end
            end
            if (!sck_on) sck_raw = 1'b0;
            else if (stall_left > 0) stall_left = stall_left - 1;
            else begin
                ssub = ssub + 1;
                if (ssub == 2) begin ssub = 0; sck_raw = ~sck_raw; end
            end
        end
    end

    // ---------------- bookkeeping ----------------
    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic wait_rises(input int n);
        for (int i = 0; i < n; i++) @(posedge lrck_raw);
        repeat (64) @(posedge clk);
        @(negedge clk);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        rst = 1'b1; supply_ok = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check("R1", "core_rst in reset", core_rst, 1'b1);
        check("R10", "force_bpz in reset", force_bpz, 1'b1);
        check("R2", "use_pll_sck in reset", use_pll_sck, 1'b0);
        check("R9", "powerdown_req in reset", powerdown_req, 1'b0);
        check("R8", "standby_req with no clocks", standby_req, 1'b1);
        rst = 1'b0; supply_ok = 1'b1;
        repeat (50) @(negedge clk);
        check("R1", "core_rst mid delay", core_rst, 1'b1);
        repeat (80) @(negedge clk);
        check("R1", "core_rst released", core_rst, 1'b0);
        supply_ok = 1'b0;
        repeat (5) @(negedge clk);
        check("R1", "core_rst after supply drop", core_rst, 1'b1);
        check("R10", "force_bpz after supply drop", force_bpz, 1'b1);
        supply_ok = 1'b1;
        repeat (130) @(negedge clk);
        check("R1", "core_rst re-released", core_rst, 1'b0);
    endtask

    task automatic t_pll_fallback();
        ratio_next = 32; sck_next = 1'b0;
        run = 1'b1;
        wait_rises(13);            // primer + 12 frames without system clock
        check("R2", "no select after 12 silent frames", use_pll_sck, 1'b0);
        check("R10", "force_bpz before first lock", force_bpz, 1'b1);
        check("R8", "standby on framing fault", standby_req, 1'b1);
        wait_rises(4);             // end of frame 16
        check("R2", "select after 16 silent frames", use_pll_sck, 1'b1);
        wait_rises(2);             // two good frames on derived clock
        check("R7", "force_bpz released after 2 good frames", force_bpz, 1'b0);
        check("R8", "standby released on lock", standby_req, 1'b0);
    endtask

    task automatic t_ext_sck();
        sck_next = 1'b1;
        wait_rises(2);
        check("R3", "external clock clears select", use_pll_sck, 1'b0);
        check("R3", "lock kept on clock swap", force_bpz, 1'b0);
        wait_rises(2);
        check("R5", "steady external clock keeps lock", force_bpz, 1'b0);
    endtask

    task automatic t_drift();
        @(posedge lrck_raw);
        repeat (40) @(negedge clk);
        stall_amt = 8; stall_req++;
        wait_rises(3);
        check("R5", "2-edge drift keeps lock", force_bpz, 1'b0);
        @(posedge lrck_raw);
        repeat (40) @(negedge clk);
        stall_amt = 32; stall_req++;
        wait_rises(1);
        check("R4", "8-edge drift forces zero", force_bpz, 1'b1);
        check("R8", "standby on drift", standby_req, 1'b1);
        wait_rises(4);
        check("R7", "relock after drift", force_bpz, 1'b0);
    endtask

    task automatic t_ratio();
        ratio_next = 48;
        wait_rises(3);
        check("R6", "ratio 48 accepted", force_bpz, 1'b0);
        ratio_next = 64;
        wait_rises(3);
        check("R6", "ratio 64 accepted", force_bpz, 1'b0);
        ratio_next = 32;
        wait_rises(3);
        check("R6", "ratio 32 accepted", force_bpz, 1'b0);
        ratio_next = 40;
        for (int i = 0; i < 4; i++) @(posedge lrck_raw);
        ratio_next = 32;
        wait_rises(2);
        check("R6", "4 invalid frames keep lock", force_bpz, 1'b0);
        wait_rises(1);
        ratio_next = 40;
        for (int i = 0; i < 5; i++) @(posedge lrck_raw);
        ratio_next = 32;
        wait_rises(1);
        check("R6", "5th invalid frame drops lock", force_bpz, 1'b1);
        check("R6", "standby on framing loss", standby_req, 1'b1);
        wait_rises(3);
        check("R7", "relock after framing loss", force_bpz, 1'b0);
    endtask

    task automatic t_halt();
        run = 1'b0;
        repeat (100) @(negedge clk);
        check("R8", "standby on halt", standby_req, 1'b1);
        check("R8", "force_bpz on halt", force_bpz, 1'b1);
        check("R9", "no power-down before timeout", powerdown_req, 1'b0);
        repeat (2100) @(negedge clk);
        check("R9", "power-down after quiet timeout", powerdown_req, 1'b1);
        run = 1'b1;
        wait_rises(4);
        check("R9", "power-down cleared on return", powerdown_req, 1'b0);
        check("R7", "lock after restart", force_bpz, 1'b0);
        check("R8", "standby cleared after restart", standby_req, 1'b0);
    endtask

    initial begin
        t_reset();
        t_pll_fallback();
        t_ext_sck();
        t_drift();
        t_ratio();
        t_halt();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule